// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers up to 31 numbered interrupt sources (1 to 31) and tells the processor the most urgent priority level that is waiting. Each source has a 4-bit control slot that holds a 3-bit priority and a pending bit. Setting the priority to zero masks the source. The slots are packed eight to a 32-bit control word, and four control words are reachable over a simple synchronous register bus.

A source is either level-sensitive or edge-sensitive, chosen per source by a build parameter. An edge source latches a request on the active edge of its input. A per-source polarity bit in a separate word selects that edge. The request stays latched until software writes the source's slot with the pending bit set. A level source simply follows its input.

When the processor runs an acknowledge cycle for a given level, the block returns a vector number one cycle later. The vector is a programmable base plus the winning source number. If no unmasked source at that level is pending, the vector is the base itself (the spurious vector).

Top module: `prio_intc`

## Requirements
- R1: After reset all priorities read 0, nothing is pending, the polarity word reads 0, the vector base reads 64, `irq_level_o` is 0 and `vec_valid_o` is 0.
- R2: Source n lives in control word (n-1)/8 (bus address 0 to 3). Its slot occupies bits [31-4*((n-1) mod 8) -: 4], so the lowest-numbered source of a word is in the top nibble. Slot bit 3 is pending and bits 2:0 are the priority.
- R3: A control write whose slot has bit 3 set loads that source's priority from bits 2:0 and clears a latched edge request. A slot with bit 3 clear changes neither priority nor pending.
- R4: Reading a control word returns the live pending state in bit 3 and the stored priority in bits 2:0 of each slot, two clock edges after a source input changes.
- R5: The polarity word (bus address 4) holds one bit per source at bit 32-n: 1 selects rising edges, 0 falling edges. A latched edge request stays pending after the input returns, until it is cleared as in R3.
- R6: A level source (parameter `LEVEL_MASK` bit n set) reads pending exactly while its input is high, and a control write cannot clear it.
- R7: `irq_level_o` equals the highest priority among pending sources, three edges after the input changes and one edge after a control write. A source with priority 0 never contributes.
- R8: An acknowledge cycle (`iack_i` high for one edge with `iack_level_i`) makes `vec_valid_o` high on the next cycle, with `vector_o` = base + n for the lowest-numbered pending source whose priority equals the requested nonzero level.
- R9: If no pending source has a nonzero priority equal to the requested level, `vector_o` is the base (spurious vector).
- R10: Sources 29 to 31 are reserved. Their inputs never make them pending, whatever their priority or polarity.
- R11: The vector base is writable at bus address 5, bits 7:0, and readable there. Later vectors use the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 3 | Word address: 0-3 control, 4 polarity, 5 vector base |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| src_i | input | 31 | Source inputs, bit k is source k+1 |
| iack_i | input | 1 | Acknowledge cycle strobe |
| iack_level_i | input | 3 | Level being acknowledged |
| irq_level_o | output | 3 | Highest pending unmasked priority |
| vector_o | output | 8 | Vector of the last acknowledge cycle |
| vec_valid_o | output | 1 | High the cycle after an acknowledge |

## Verification
Each result has a fixed latency. A source input change becomes visible in the read data two edges later and in `irq_level_o` three edges later. A control write changes the read data at its own edge and the level one edge after. An acknowledge vector comes out on the edge after `iack_i` is sampled. The bench drives every input just after a rising edge and waits that exact number of edges before it samples the read data and level. Expected vectors go into a queue when an acknowledge is issued. A monitor on the falling edge pops one for each cycle that `vec_valid_o` is high, so a vector that arrives early, late or not at all is reported.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int SLOT_W    = 4;
  localparam int PRIO_W    = 3;
  localparam int WORD_W    = 32;
  localparam int SLOTS_PER = WORD_W / SLOT_W;

  // low bit of the slot for zero-based source index idx (source idx+1)
  function automatic int slot_lsb(input int idx);
    return WORD_W - SLOT_W - SLOT_W * (idx % SLOTS_PER);
  endfunction

  // bit of the polarity word for zero-based source index idx
  function automatic int pol_bit(input int idx);
    return WORD_W - 1 - idx;
  endfunction
endpackage

// File: rtl/prio_intc_src.sv
module prio_intc_src #(
  parameter int          NUM_SRC    = 31,
  parameter int          RESV_FIRST = 29,
  parameter logic [31:0] LEVEL_MASK = 32'h03FF_FFE0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] rise_sel_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  localparam logic [NUM_SRC-1:0] LIVE_MASK = NUM_SRC'((64'd1 << (RESV_FIRST - 1)) - 64'd1);

  logic [NUM_SRC-1:0] smp_q, smp_d;
  logic [NUM_SRC-1:0] old_q, old_d;
  logic [NUM_SRC-1:0] pend_q, pend_d;
  logic [NUM_SRC-1:0] hit;

  // reserved inputs are cut before the first flop
  always_comb begin
    smp_d = src_i & LIVE_MASK;
    old_d = smp_q;
    hit   = (rise_sel_i & smp_q & ~old_q) | (~rise_sel_i & ~smp_q & old_q);
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (LEVEL_MASK[i+1] && (i + 1 < RESV_FIRST)) begin : g_level
      always_comb pend_d[i] = smp_q[i];
    end else begin : g_edge
      // a fresh edge outranks a clear in the same cycle
      always_comb pend_d[i] = hit[i] | (pend_q[i] & ~clr_i[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= '0;
      old_q  <= '0;
      pend_q <= '0;
    end else begin
      smp_q  <= smp_d;
      old_q  <= old_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
  import prio_intc_pkg::*;
#(
  parameter int          NUM_SRC  = 31,
  parameter int          AW       = 3,
  parameter int          VEC_W    = 8,
  parameter logic [7:0]  BASE_RST = 8'd64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_sel_i,
  input  logic                           bus_we_i,
  input  logic [AW-1:0]                  bus_addr_i,
  input  logic [WORD_W-1:0]              bus_wdata_i,
  output logic [WORD_W-1:0]              bus_rdata_o,
  input  logic [NUM_SRC-1:0]             pend_i,
  output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o,
  output logic [NUM_SRC-1:0]             rise_sel_o,
  output logic [NUM_SRC-1:0]             clr_o,
  output logic [VEC_W-1:0]               base_o
);
  localparam int NUM_CTRL   = (NUM_SRC + SLOTS_PER - 1) / SLOTS_PER;
  localparam int ADDR_POL   = NUM_CTRL;
  localparam int ADDR_BASE  = NUM_CTRL + 1;

  logic [NUM_CTRL-1:0]             ctrl_we;
  logic                            pol_we, base_we;
  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_q, prio_d;
  logic [NUM_SRC-1:0]              pol_q, pol_d;
  logic [VEC_W-1:0]                base_q, base_d;
  logic [NUM_CTRL-1:0][WORD_W-1:0] ctrl_rd;
  logic [WORD_W-1:0]               pol_rd;

  // write decode
  for (genvar r = 0; r < NUM_CTRL; r++) begin : g_dec
    assign ctrl_we[r] = bus_sel_i & bus_we_i & (bus_addr_i == AW'(r));
  end
  assign pol_we  = bus_sel_i & bus_we_i & (bus_addr_i == AW'(ADDR_POL));
  assign base_we = bus_sel_i & bus_we_i & (bus_addr_i == AW'(ADDR_BASE));

  // per-source slot next state
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
    localparam int WRD = i / SLOTS_PER;
    localparam int LSB = slot_lsb(i);
    localparam int PB  = pol_bit(i);
    assign clr_o[i]  = ctrl_we[WRD] & bus_wdata_i[LSB+PRIO_W];
    assign prio_d[i] = clr_o[i] ? bus_wdata_i[LSB +: PRIO_W] : prio_q[i];
    assign pol_d[i]  = pol_we ? bus_wdata_i[PB] : pol_q[i];
  end

  assign base_d = base_we ? bus_wdata_i[VEC_W-1:0] : base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      pol_q  <= '0;
      base_q <= VEC_W'(BASE_RST);
    end else begin
      prio_q <= prio_d;
      pol_q  <= pol_d;
      base_q <= base_d;
    end
  end

  // read path
  always_comb begin
    ctrl_rd = '0;
    pol_rd  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      ctrl_rd[i/SLOTS_PER][slot_lsb(i) +: SLOT_W] = {pend_i[i], prio_q[i]};
      pol_rd[pol_bit(i)] = pol_q[i];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int r = 0; r < NUM_CTRL; r++) begin
      if (bus_addr_i == AW'(r)) bus_rdata_o = ctrl_rd[r];
    end
    if (bus_addr_i == AW'(ADDR_POL))  bus_rdata_o = pol_rd;
    if (bus_addr_i == AW'(ADDR_BASE)) bus_rdata_o = WORD_W'(base_q);
  end

  assign prio_o     = prio_q;
  assign rise_sel_o = pol_q;
  assign base_o     = base_q;
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int VEC_W   = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0]             pend_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [VEC_W-1:0]               base_i,
  input  logic                           iack_i,
  input  logic [PRIO_W-1:0]              iack_level_i,
  output logic [PRIO_W-1:0]              irq_level_o,
  output logic [VEC_W-1:0]               vector_o,
  output logic                           vec_valid_o
);
  logic [PRIO_W-1:0] lvl_d, lvl_q;
  logic [VEC_W-1:0]  pick;
  logic [VEC_W-1:0]  vec_d, vec_q;
  logic              vld_d, vld_q;

  // highest live priority; priority 0 can never win
  always_comb begin
    lvl_d = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i] && (prio_i[i] > lvl_d)) lvl_d = prio_i[i];
    end
  end

  // scan downward so the lowest-numbered match is the last one kept
  always_comb begin
    pick = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i] && (iack_level_i != '0) && (prio_i[i] == iack_level_i))
        pick = VEC_W'(i + 1);
    end
    vec_d = iack_i ? (base_i + pick) : vec_q;
    vld_d = iack_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      vec_q <= '0;
      vld_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      vec_q <= vec_d;
      vld_q <= vld_d;
    end
  end

  assign irq_level_o = lvl_q;
  assign vector_o    = vec_q;
  assign vec_valid_o = vld_q;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int          NUM_SRC    = 31,
  parameter int          RESV_FIRST = 29,
  parameter int          AW         = 3,
  parameter int          VEC_W      = 8,
  parameter logic [7:0]  BASE_RST   = 8'd64,
  parameter logic [31:0] LEVEL_MASK = 32'h03FF_FFE0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel_i,
  input  logic               bus_we_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               iack_i,
  input  logic [2:0]         iack_level_i,
  output logic [2:0]         irq_level_o,
  output logic [VEC_W-1:0]   vector_o,
  output logic               vec_valid_o
);
  logic                           rst_s1_q, rst_s2_q;
  logic                           rst_core_n;
  logic [NUM_SRC-1:0]             pend_w;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_w;
  logic [NUM_SRC-1:0]             rise_w;
  logic [NUM_SRC-1:0]             clr_w;
  logic [VEC_W-1:0]               base_w;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_core_n = rst_s2_q;

  prio_intc_src #(
    .NUM_SRC(NUM_SRC), .RESV_FIRST(RESV_FIRST), .LEVEL_MASK(LEVEL_MASK)
  ) u_src (
    .clk(clk), .rst_n(rst_core_n), .src_i(src_i),
    .rise_sel_i(rise_w), .clr_i(clr_w), .pend_o(pend_w)
  );

  prio_intc_regs #(
    .NUM_SRC(NUM_SRC), .AW(AW), .VEC_W(VEC_W), .BASE_RST(BASE_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .pend_i(pend_w), .prio_o(prio_w), .rise_sel_o(rise_w),
    .clr_o(clr_w), .base_o(base_w)
  );

  prio_intc_arb #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W)
  ) u_arb (
    .clk(clk), .rst_n(rst_core_n), .pend_i(pend_w), .prio_i(prio_w),
    .base_i(base_w), .iack_i(iack_i), .iack_level_i(iack_level_i),
    .irq_level_o(irq_level_o), .vector_o(vector_o), .vec_valid_o(vec_valid_o)
  );
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int NUM_SRC    = 31,
  parameter int RESV_FIRST = 29,
  parameter int AW         = 3,
  parameter int VEC_W      = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_sel_i,
  input logic                     bus_we_i,
  input logic [AW-1:0]            bus_addr_i,
  input logic [31:0]              bus_wdata_i,
  input logic                     iack_i,
  input logic [2:0]               irq_level_o,
  input logic [VEC_W-1:0]         vector_o,
  input logic                     vec_valid_o,
  input logic [NUM_SRC-1:0]       pend_w,
  input logic [NUM_SRC-1:0][2:0]  prio_w,
  input logic [VEC_W-1:0]         base_w
);
  // R8
  vec_after_iack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> $past(iack_i));

  // R8
  vec_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_i |=> !vec_valid_o);

  // R9
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> ((vector_o - $past(base_w)) < VEC_W'(RESV_FIRST)));

  // R7
  level_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level_o != 3'd0) |-> $past(|pend_w));

  // R3
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_we_i && bus_addr_i == '0 && !bus_wdata_i[31])
      |=> $stable(prio_w[0]));
endmodule

bind prio_intc prio_intc_chk #(
  .NUM_SRC(NUM_SRC), .RESV_FIRST(RESV_FIRST), .AW(AW), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .iack_i(iack_i),
  .irq_level_o(irq_level_o), .vector_o(vector_o), .vec_valid_o(vec_valid_o),
  .pend_w(pend_w), .prio_w(prio_w), .base_w(base_w)
);

// File: tb/prio_intc_test.sv
module prio_intc_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [30:0] src;
  logic        iack;
  logic [2:0]  iack_lvl;
  logic [2:0]  irq_level;
  logic [7:0]  vector;
  logic        vec_valid;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #5 clk = ~clk;

  prio_intc uut (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .src_i(src), .iack_i(iack), .iack_level_i(iack_lvl),
    .irq_level_o(irq_level), .vector_o(vector), .vec_valid_o(vec_valid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  // driver: issue acknowledge and queue the expected vector
  task automatic ack_cycle(input string tag, input logic [2:0] lvl, input logic [7:0] exp);
    iack = 1'b1; iack_lvl = lvl;
    exp_q.push_back(exp); tag_q.push_back(tag);
    step(1);
    iack = 1'b0;
  endtask

  // monitor: every valid vector must match the oldest expectation
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected vector", {24'd0, vector}, 32'hFFFF_FFFF);
      end else begin
        check(tag_q.pop_front(), {24'd0, vector}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    src = '0; iack = 0; iack_lvl = '0;
    step(3);
    rst_n = 1'b1;
    step(3);

    // R1 reset state
    check("R1 level", {29'd0, irq_level}, 0);
    check("R1 valid", {31'd0, vec_valid}, 0);
    rd_chk("R1 ctrl0", 3'd0, 32'h0);
    rd_chk("R1 polarity", 3'd4, 32'h0);
    rd_chk("R1 base", 3'd5, 32'd64);

    // R2 R3 slot layout: s1=3, s2=5, s3=5, s4 untouched, s5=2
    bus_wr(3'd0, 32'hBDD0_A000);
    rd_chk("R2 slot layout", 3'd0, 32'h3550_2000);
    bus_wr(3'd0, 32'h7000_0000);
    rd_chk("R3 bit3 clear keeps priority", 3'd0, 32'h3550_2000);

    // R5 polarity: s1 and s3 rising, s2 falling
    bus_wr(3'd4, 32'hA000_0000);
    rd_chk("R5 polarity readback", 3'd4, 32'hA000_0000);

    // R6 R4 level source 5
    src[4] = 1'b1;
    step(2);
    rd_chk("R4 R6 level pending visible", 3'd0, 32'h3550_A000);
    step(1);
    check("R7 level from s5", {29'd0, irq_level}, 2);

    // R5 rising edge on s1, held after input drops
    src[0] = 1'b1;
    step(3);
    check("R7 level from s1", {29'd0, irq_level}, 3);
    src[0] = 1'b0;
    step(3);
    check("R5 edge stays pending", {29'd0, irq_level}, 3);

    ack_cycle("R8 vector s1", 3'd3, 8'd65);
    ack_cycle("R8 vector s5", 3'd2, 8'd69);
    ack_cycle("R9 no match level5", 3'd5, 8'd64);
    ack_cycle("R9 level zero", 3'd0, 8'd64);

    // R5 falling-mode s2 ignores rise, latches fall
    src[1] = 1'b1;
    step(3);
    check("R5 rise ignored in falling mode", {29'd0, irq_level}, 3);
    src[1] = 1'b0;
    step(3);
    check("R5 falling edge latched", {29'd0, irq_level}, 5);
    src[2] = 1'b1;
    step(3);
    ack_cycle("R8 tie lowest number wins", 3'd5, 8'd66);

    // R3 clear s2 then s3
    bus_wr(3'd0, 32'h0D00_0000);
    step(1);
    check("R3 clear s2 leaves s3", {29'd0, irq_level}, 5);
    ack_cycle("R8 vector s3", 3'd5, 8'd67);
    bus_wr(3'd0, 32'h00D0_0000);
    step(1);
    check("R3 clear s3", {29'd0, irq_level}, 3);

    // R7 mask s5 while input high, then clear s1
    bus_wr(3'd0, 32'h0000_8000);
    bus_wr(3'd0, 32'hB000_0000);
    step(1);
    check("R7 masked source gives level 0", {29'd0, irq_level}, 0);
    rd_chk("R6 masked level still pending", 3'd0, 32'h3550_8000);
    bus_wr(3'd0, 32'h0000_8000);
    rd_chk("R6 clear cannot drop level source", 3'd0, 32'h3550_8000);
    ack_cycle("R9 masked not selected", 3'd2, 8'd64);

    // R10 reserved source 29 (word 3, bits 15:12, polarity bit 3)
    bus_wr(3'd3, 32'h0000_F000);
    bus_wr(3'd4, 32'hA000_0008);
    src[28] = 1'b1;
    step(3);
    check("R10 reserved level", {29'd0, irq_level}, 0);
    rd_chk("R10 reserved not pending", 3'd3, 32'h0000_7000);

    // R11 base change, edge source 26 (word 3 bits 27:24, polarity bit 6)
    bus_wr(3'd3, 32'h0E00_0000);
    bus_wr(3'd4, 32'hA000_0048);
    bus_wr(3'd5, 32'h0000_0020);
    rd_chk("R11 base readback", 3'd5, 32'h20);
    src[25] = 1'b1;
    step(3);
    check("R7 level from s26", {29'd0, irq_level}, 6);
    ack_cycle("R11 vector with new base", 3'd6, 8'h3A);

    // R6 level source drop
    src[4] = 1'b0;
    step(2);
    rd_chk("R6 level pending follows input", 3'd0, 32'h3550_0000);

    step(3);
    check("R8 all vectors delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule